// File: doc/BRIEF.md
# Circular Buffer Readout Sequencer

This block empties a circular sample memory of 2^ADDR_W words toward a host, in time order. When the capture side finishes filling the ring, it raises a read enable and presents the address of the oldest sample it wants returned. The sequencer turns that one circular window into linear burst requests for a bus master. Each request carries a start address and a word count.

When the oldest sample sits at address 0, the whole ring goes out as a single burst. In every other case the readout takes two bursts:

- the first burst runs from the oldest sample up to the top of the memory;
- the second burst covers the bottom of the memory up to the word just below the start.

Each request is held until the master takes it. The next request is not issued until the master reports that the previous burst was acknowledged by the receiver. After the last burst, a one-cycle completion pulse goes back to the capture side and the block falls idle.

Top module: `ring_readout_seq`

## Requirements
- R1: A readout starts only on a rising edge of `rd_en` (low in one cycle, high in the next) while the block is idle. `rd_base` is sampled in that cycle, and later changes to `rd_base` have no effect on the readout in progress. The first request is visible in the cycle after the rising edge is sampled.
- R2: When the sampled base is 0, exactly one burst is requested, with `req_addr` = 0 and `req_len` = 2^ADDR_W.
- R3: When the sampled base B is nonzero, the first burst has `req_addr` = B and `req_len` = 2^ADDR_W − B. No burst runs past address 2^ADDR_W − 1.
- R4: When B is nonzero, a second burst follows with `req_addr` = 0 and `req_len` = B.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_len` hold steady. In the cycle after a clock edge that sees both `req_valid` and `req_ready` high, `req_valid` is low.
- R6: After a burst is accepted, no further request appears until `burst_ack` is sampled high. A `burst_ack` that arrives while a request is still pending is ignored.
- R7: `rd_done` is high for exactly one cycle: the cycle after the `burst_ack` of the final burst is sampled. `req_valid` is low while `rd_done` is high.
- R8: After `rd_done`, the block is idle. An `rd_en` that stays high, or that rose while a readout was in progress, starts nothing; a fresh rising edge is needed.
- R9: After reset, `req_valid` and `rd_done` are low, and `req_addr` and `req_len` read 0 whenever no request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read enable from the capture controller |
| rd_base | input | ADDR_W | Address of the oldest sample in the ring |
| req_valid | output | 1 | Burst request pending toward the bus master |
| req_ready | input | 1 | Master accepts the pending request |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | ADDR_W+1 | Burst length in words |
| burst_ack | input | 1 | Master reports the accepted burst acknowledged and sent |
| rd_done | output | 1 | One-cycle completion pulse to the capture controller |

## Verification
The bench builds the block with ADDR_W = 4, giving a 16-word ring. With only 16 possible bases, every start address can be reached, including 0, the midpoint 8 and the top word 15, alongside seeded random bases. Master handshakes are exercised with random accept delays and random acknowledge delays, including zero. Stray acknowledges sent while a request is pending, read-enable toggling during a readout, and base changes after the start are mixed in.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic [2:0] {
    RS_IDLE   = 3'd0,
    RS_REQ_A  = 3'd1,
    RS_WAIT_A = 3'd2,
    RS_REQ_B  = 3'd3,
    RS_WAIT_B = 3'd4,
    RS_DONE   = 3'd5
  } rrs_state_e;

endpackage

// File: rtl/rrs_rise.sv
// Rising-edge detector for the read enable; the history register tracks
// the input in every cycle so an edge seen while busy is consumed.
module rrs_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_i;
    end
  end

  assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/rrs_split.sv
// Splits a circular window starting at base into one or two linear bursts.
module rrs_split #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W:0]   first_len_o,
  output logic [ADDR_W:0]   second_len_o,
  output logic              two_burst_o
);

  localparam int unsigned LEN_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(1) << ADDR_W;

  always_comb begin
    first_len_o  = DEPTH_L - {1'b0, base_i};
    second_len_o = {1'b0, base_i};
    two_burst_o  = |base_i;
  end

endmodule

// File: rtl/rrs_fsm.sv
// Burst sequencing state machine.
module rrs_fsm
  import rrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       two_burst_i,
  input  logic       req_ready_i,
  input  logic       burst_ack_i,
  output rrs_state_e state_o
);

  rrs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE:   if (start_i)     state_d = RS_REQ_A;
      RS_REQ_A:  if (req_ready_i) state_d = RS_WAIT_A;
      RS_WAIT_A: if (burst_ack_i) state_d = two_burst_i ? RS_REQ_B : RS_DONE;
      RS_REQ_B:  if (req_ready_i) state_d = RS_WAIT_B;
      RS_WAIT_B: if (burst_ack_i) state_d = RS_DONE;
      RS_DONE:                    state_d = RS_IDLE;
      default:                    state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/ring_readout_seq.sv
module ring_readout_seq
  import rrs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W:0]   req_len,
  input  logic              burst_ack,
  output logic              rd_done
);

  logic              rise;
  logic              load_en;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W:0]   first_len;
  logic [ADDR_W:0]   second_len;
  logic              two_burst;
  rrs_state_e        state;

  rrs_rise u_rise (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (rd_en),
    .rise_o  (rise)
  );

  assign load_en = (state == RS_IDLE) & rise;

  // Base address register with an explicit load enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (load_en) begin
      base_q <= rd_base;
    end
  end

  rrs_split #(.ADDR_W(ADDR_W)) u_split (
    .base_i       (base_q),
    .first_len_o  (first_len),
    .second_len_o (second_len),
    .two_burst_o  (two_burst)
  );

  rrs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (rise),
    .two_burst_i (two_burst),
    .req_ready_i (req_ready),
    .burst_ack_i (burst_ack),
    .state_o     (state)
  );

  always_comb begin
    req_valid = 1'b0;
    req_addr  = '0;
    req_len   = '0;
    if (state == RS_REQ_A) begin
      req_valid = 1'b1;
      req_addr  = base_q;
      req_len   = first_len;
    end else if (state == RS_REQ_B) begin
      req_valid = 1'b1;
      req_len   = second_len;
    end
  end

  assign rd_done = (state == RS_DONE);

endmodule

// File: rtl/ring_readout_seq_chk.sv
module ring_readout_seq_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W:0]   req_len,
  input logic              rd_done
);

  localparam int unsigned SUM_W = ADDR_W + 2;
  localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(1) << ADDR_W;

  // R5
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));

  // R5
  drop_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  // R3
  burst_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) &&
                  (({2'b00, req_addr} + {1'b0, req_len}) <= DEPTH_S));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !req_valid);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (req_addr == '0) && (req_len == '0));

endmodule

bind ring_readout_seq ring_readout_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_len   (req_len),
  .rd_done   (rd_done)
);

// File: tb/test_ring_readout_seq.sv
module test_ring_readout_seq;

  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_base;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [ADDR_W:0]   req_len;
  logic              burst_ack;
  logic              rd_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ring_readout_seq #(.ADDR_W(ADDR_W)) i_ring_readout_seq (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_base(rd_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .burst_ack(burst_ack), .rd_done(rd_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below %0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_bursts(input int sa);
    return (sa == 0) ? 1 : 2;
  endfunction

  function automatic int exp_addr(input int sa, input int k);
    return (k == 0) ? sa : 0;
  endfunction

  function automatic int exp_len(input int sa, input int k);
    return (k == 0) ? DEPTH - sa : sa;
  endfunction

  task automatic run(input int sa, input int rdy_dly, input int ack_dly,
                     input bit poke_ack, input bit toggle_rd);
    @(negedge clk);
    rd_base = ADDR_W'(sa);
    rd_en   = 1'b1;
    @(negedge clk);
    rd_base = ADDR_W'($urandom_range(0, DEPTH - 1));   // R1 late change ignored
    for (int k = 0; k < exp_bursts(sa); k++) begin
      int w = 0;
      while (!req_valid && w < 50) begin
        @(negedge clk);
        w++;
      end
      chk("R1 request latency", w, 0);
      if (sa == 0)
        chk("R2 single burst addr", int'(req_addr), 0);
      else if (k == 0)
        chk("R3 first burst addr", int'(req_addr), exp_addr(sa, k));
      else
        chk("R4 second burst addr", int'(req_addr), exp_addr(sa, k));
      if (sa == 0)
        chk("R2 single burst len", int'(req_len), DEPTH);
      else if (k == 0)
        chk("R3 first burst len", int'(req_len), exp_len(sa, k));
      else
        chk("R4 second burst len", int'(req_len), exp_len(sa, k));
      for (int d = 0; d < rdy_dly; d++) begin
        if (poke_ack) burst_ack = 1'b1;
        @(negedge clk);
        burst_ack = 1'b0;
        chk("R5 request held", int'(req_valid), 1);
        chk("R6 stray ack ignored, len stable", int'(req_len),
            (sa == 0) ? DEPTH : exp_len(sa, k));
        chk("R5 addr stable", int'(req_addr), exp_addr(sa, k));
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      chk("R5 valid drops after accept", int'(req_valid), 0);
      for (int d = 0; d < ack_dly; d++) begin
        if (toggle_rd) rd_en = ~rd_en;
        @(negedge clk);
        chk("R6 no request before ack", int'(req_valid), 0);
        chk("R7 no early done", int'(rd_done), 0);
      end
      rd_en = 1'b1;
      burst_ack = 1'b1;
      @(negedge clk);
      burst_ack = 1'b0;
    end
    chk("R7 done pulse", int'(rd_done), 1);
    chk("R7 no request with done", int'(req_valid), 0);
    @(negedge clk);
    chk("R7 done single cycle", int'(rd_done), 0);
    for (int d = 0; d < 3; d++) begin
      @(negedge clk);
      chk("R8 held enable does not restart", int'(req_valid), 0);
    end
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; rd_en = 1'b0; rd_base = '0;
    req_ready = 1'b0; burst_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset valid", int'(req_valid), 0);
    chk("R9 reset done", int'(rd_done), 0);
    chk("R9 reset addr", int'(req_addr), 0);
    chk("R9 reset len", int'(req_len), 0);

    // R1: no enable edge, no request while base moves
    for (int d = 0; d < 4; d++) begin
      rd_base = ADDR_W'(d * 5);
      @(negedge clk);
      chk("R1 idle without enable", int'(req_valid), 0);
    end

    // directed corners: base 0, midpoint, top word, 1
    run(0, 0, 0, 1'b0, 1'b0);
    run(DEPTH / 2, 2, 1, 1'b1, 1'b0);
    run(DEPTH - 1, 0, 3, 1'b0, 1'b1);
    run(1, 3, 0, 1'b1, 1'b1);
    run(0, 2, 2, 1'b1, 1'b1);

    for (int n = 0; n < 60; n++) begin
      run($urandom_range(0, DEPTH - 1), $urandom_range(0, 3), $urandom_range(0, 3),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule